// File: doc/BRIEF.md
# Maskable Interrupt Controller with Master Enable

This block gathers sixteen interrupt lines from peripherals and condenses them into one request for a processor. It looks at the lines on the falling clock edge and detects low-to-high transitions. Each transition passes through a per-source enable bit. A transition that passes sets a sticky pending bit. Above the per-source enables sits one master enable bit. The processor sees a request only while that bit is set and something is pending. The request carries the index of the winning source: the lowest-numbered pending source wins. The processor answers with an acknowledge, which retires that source.

Software reaches the controller through a port-style bus: an address, a write strobe with write data, and a read strobe. Register writes and event capture take effect on the falling clock edge. Read data, the request and the vector index are registered on the rising edge. One module-enable input acts as a synchronous clock enable on every register in the block, so the whole controller holds still while it is idle. The request, acknowledge and bus strobes are plain control pins; the block moves no data stream, so none of its pins has a valid/ready handshake.

The number of sources is a parameter and must not exceed the data width.

Top module: `irq_mask_ctl`

## Requirements
- R1: On each falling edge, a source whose input is high and was low at the previous falling edge raises an event. An input held high raises only one event.
- R2: The source-enable register sits at address 0x0000, where bit i set means source i is allowed. An event on a source whose bit is clear is discarded, and it stays discarded after the bit is later set.
- R3: The pending register sits at address 0x0001 and its bits are sticky. Writing a 1 to bit i clears that bit. An event arriving on the same falling edge as the clear wins.
- R4: The control register sits at address 0x0002, with bit 0 as the master enable. `cpu_req` is raised only while the master enable is 1 and some pending bit is set. Pending sources with the master enable at 0 produce no request. Setting the master enable raises the request at the next rising edge.
- R5: While `cpu_req` is high, `cpu_vec` holds the lowest-numbered pending source. Request and vector are updated at the first rising edge after the falling edge that changed the pending bits.
- R6: `cpu_ack` high while `cpu_req` is high clears the pending bit of the source in `cpu_vec` at the falling edge. `cpu_req` is then low for exactly the next cycle, and arbitration resumes one cycle after that.
- R7: Reset (`rst_n` low) returns the source enables, pending bits, master enable, request, vector and read data to zero.
- R8: While `mod_en` is low, no register changes. Writes, input transitions and acknowledges are all ignored, and `cpu_req`, `cpu_vec` and `port_rdata` hold their values.
- R9: `port_rd` loads `port_rdata` at the rising edge that ends the strobe cycle, and `port_rdata` holds between reads. Address 0x0003 reads the request in bit 15 and the vector in the low bits. Any other unmapped address reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; falling edge captures events and writes, rising edge updates outputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_en | input | 1 | Module enable; low freezes all state |
| irq_in | input | N_SRC | Interrupt lines from peripherals |
| port_addr | input | ADDR_W | Register address |
| port_wr | input | 1 | Write strobe |
| port_rd | input | 1 | Read strobe |
| port_wdata | input | DATA_W | Write data |
| port_rdata | output | DATA_W | Registered read data |
| cpu_req | output | 1 | Interrupt request to the processor |
| cpu_vec | output | VEC_W | Index of the source being requested |
| cpu_ack | input | 1 | Acknowledge from the processor |

## Verification
Inputs are driven a quarter period after a rising edge. The falling edge in the middle of that same cycle captures events, writes and acknowledges. `cpu_req`, `cpu_vec` and `port_rdata` therefore respond at the next rising edge, one cycle after the stimulus. The bench samples every result a quarter period after that rising edge and drives the next stimulus at the same point. After an acknowledge, the bench expects `cpu_req` low at exactly the first sample and the next winner at the second sample. It walks every source singly and several multi-source patterns, retiring each pending bit in ascending order.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // Register addresses on the port bus
  localparam int unsigned ADR_ENABLE  = 32'h0000;
  localparam int unsigned ADR_PENDING = 32'h0001;
  localparam int unsigned ADR_CONTROL = 32'h0002;
  localparam int unsigned ADR_VECTOR  = 32'h0003;
endpackage

// File: rtl/irqc_edge.sv
module irqc_edge #(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [N-1:0] raw,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev_q;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)  prev_q <= '0;
    else if (en) prev_q <= raw;
  end

  assign rise = raw & ~prev_q;
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs import irqc_pkg::*; #(
  parameter int unsigned N      = 16,
  parameter int unsigned ADDR_W = 16,
  localparam int unsigned VW    = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N-1:0]  wdata,
  input  logic [N-1:0]  rise,
  input  logic          ack_hit,
  input  logic [VW-1:0] ack_idx,
  output logic [N-1:0]  enable_q,
  output logic [N-1:0]  pend_q,
  output logic          master_q
);
  logic          wr_enable, wr_pending, wr_control;
  logic [N-1:0]  clr_sw, clr_ack, pend_next;
  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  assign wr_enable  = wr && (addr == ADDR_W'(ADR_ENABLE));
  assign wr_pending = wr && (addr == ADDR_W'(ADR_PENDING));
  assign wr_control = wr && (addr == ADDR_W'(ADR_CONTROL));

  always_comb begin
    clr_sw    = wr_pending ? wdata : '0;
    clr_ack   = ack_hit ? (ONE << ack_idx) : '0;
    pend_next = (pend_q & ~clr_sw & ~clr_ack) | (rise & enable_q);
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= '0;
      pend_q   <= '0;
      master_q <= 1'b0;
    end else if (en) begin
      if (wr_enable)  enable_q <= wdata;
      if (wr_control) master_q <= wdata[0];
      pend_q <= pend_next;
    end
  end

  // R8: module enable low freezes every register here
  p_freeze_regs_r8: assert property (@(negedge clk) disable iff (!rst_n)
    !en |=> ($stable(enable_q) && $stable(pend_q) && $stable(master_q)));

  // R2: a newly pending bit must belong to an enabled source
  p_masked_drop_r2: assert property (@(negedge clk) disable iff (!rst_n)
    en |=> ((pend_q & ~$past(pend_q) & ~$past(enable_q)) == '0));
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int unsigned N = 16,
  localparam int unsigned VW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  pend,
  output logic          any,
  output logic [VW-1:0] idx
);
  always_comb begin
    any = |pend;
    idx = '0;
    for (int i = int'(N) - 1; i >= 0; i--) begin
      if (pend[i]) idx = VW'(i);
    end
  end
endmodule

// File: rtl/irq_mask_ctl.sv
module irq_mask_ctl import irqc_pkg::*; #(
  parameter int unsigned N_SRC  = 16,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned VEC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mod_en,
  input  logic [N_SRC-1:0]  irq_in,
  input  logic [ADDR_W-1:0] port_addr,
  input  logic              port_wr,
  input  logic              port_rd,
  input  logic [DATA_W-1:0] port_wdata,
  output logic [DATA_W-1:0] port_rdata,
  output logic              cpu_req,
  output logic [VEC_W-1:0]  cpu_vec,
  input  logic              cpu_ack
);
  logic [N_SRC-1:0]  rise, enable_q, pend_q;
  logic              master_q, any_pend, ack_hit, fire;
  logic [VEC_W-1:0]  win_idx, vec_q;
  logic              req_q;
  logic [DATA_W-1:0] rd_mux, rdata_q;

  assign ack_hit = req_q & cpu_ack;
  assign fire    = master_q & any_pend;

  irqc_edge #(.N(N_SRC)) u_edge (
    .clk(clk), .rst_n(rst_n), .en(mod_en), .raw(irq_in), .rise(rise)
  );

  irqc_regs #(.N(N_SRC), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .en(mod_en), .wr(port_wr), .addr(port_addr),
    .wdata(port_wdata[N_SRC-1:0]), .rise(rise), .ack_hit(ack_hit),
    .ack_idx(vec_q), .enable_q(enable_q), .pend_q(pend_q), .master_q(master_q)
  );

  irqc_prio #(.N(N_SRC)) u_prio (
    .pend(pend_q), .any(any_pend), .idx(win_idx)
  );

  always_comb begin
    rd_mux = '0;
    if (port_addr == ADDR_W'(ADR_ENABLE))       rd_mux[N_SRC-1:0] = enable_q;
    else if (port_addr == ADDR_W'(ADR_PENDING)) rd_mux[N_SRC-1:0] = pend_q;
    else if (port_addr == ADDR_W'(ADR_CONTROL)) rd_mux[0] = master_q;
    else if (port_addr == ADDR_W'(ADR_VECTOR)) begin
      rd_mux[VEC_W-1:0]  = vec_q;
      rd_mux[DATA_W-1]   = req_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      vec_q   <= '0;
      rdata_q <= '0;
    end else if (mod_en) begin
      if (ack_hit) begin
        req_q <= 1'b0;
      end else begin
        req_q <= fire;
        if (fire) vec_q <= win_idx;
      end
      if (port_rd) rdata_q <= rd_mux;
    end
  end

  assign cpu_req    = req_q;
  assign cpu_vec    = vec_q;
  assign port_rdata = rdata_q;

  // Helpers for the priority check
  logic [N_SRC-1:0] vec_bit, vec_upto;
  assign vec_bit  = {{(N_SRC-1){1'b0}}, 1'b1} << vec_q;
  assign vec_upto = (vec_bit << 1) - 1'b1;

  // R4: a request implies master enable was set when it was formed
  p_req_needs_master_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> $past(master_q));

  // R5: the vector is pending and nothing lower-numbered was pending
  p_vec_lowest_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> (($past(pend_q) & vec_upto) == vec_bit));

  // R6: an accepted acknowledge drops the request for the next cycle
  p_ack_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en && req_q && cpu_ack) |=> !req_q);

  // R8: outputs hold while the module is disabled
  p_freeze_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_en |=> ($stable(req_q) && $stable(vec_q) && $stable(rdata_q)));
endmodule

// File: tb/irq_mask_ctl_bench.sv
module irq_mask_ctl_bench;
  localparam int CLK_P = 10;
  localparam logic [15:0] A_EN = 16'h0000, A_PD = 16'h0001, A_CT = 16'h0002, A_VC = 16'h0003;

  logic        clk = 1'b0;
  logic        rst_n, mod_en, port_wr, port_rd, cpu_ack, cpu_req;
  logic [15:0] irq_in, port_addr, port_wdata, port_rdata;
  logic [3:0]  cpu_vec;
  int          total = 0, bad = 0;
  bit          done = 0;

  always #(CLK_P/2) clk = ~clk;

  irq_mask_ctl u_irq_mask_ctl (
    .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .irq_in(irq_in),
    .port_addr(port_addr), .port_wr(port_wr), .port_rd(port_rd),
    .port_wdata(port_wdata), .port_rdata(port_rdata),
    .cpu_req(cpu_req), .cpu_vec(cpu_vec), .cpu_ack(cpu_ack)
  );

  task automatic tick();
    @(posedge clk);
    #(CLK_P/4);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [15:0] a, input logic [15:0] d);
    port_addr = a; port_wdata = d; port_wr = 1'b1;
    tick();
    port_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [15:0] a, output logic [15:0] d);
    port_addr = a; port_rd = 1'b1;
    tick();
    port_rd = 1'b0;
    d = port_rdata;
  endtask

  task automatic ack_once();
    cpu_ack = 1'b1;
    tick();
    cpu_ack = 1'b0;
  endtask

  function automatic int lowest(input logic [15:0] v);
    for (int i = 0; i < 16; i++) if (v[i]) return i;
    return -1;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] d, rem, pat;
    int e;
    rst_n = 1'b0; mod_en = 1'b1; irq_in = '0; port_addr = '0;
    port_wr = 1'b0; port_rd = 1'b0; port_wdata = '0; cpu_ack = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R7 reset defaults
    chk("R7 req", 32'(cpu_req), 0);
    rd_reg(A_EN, d); chk("R7 enable", 32'(d), 0);
    rd_reg(A_PD, d); chk("R7 pending", 32'(d), 0);
    rd_reg(A_CT, d); chk("R7 control", 32'(d), 0);

    wr_reg(A_EN, 16'hFFFF);
    wr_reg(A_CT, 16'h0001);
    rd_reg(A_EN, d); chk("R9 enable readback", 32'(d), 32'hFFFF);

    // Every source alone
    for (int i = 0; i < 16; i++) begin
      irq_in = 16'(1 << i);
      tick();
      irq_in = '0;
      chk("R5 single req", 32'(cpu_req), 1);
      chk("R5 single vec", 32'(cpu_vec), 32'(i));
      rd_reg(A_PD, d); chk("R3 single pending", 32'(d), 32'(1 << i));
      ack_once();
      chk("R6 drop after ack", 32'(cpu_req), 0);
      rd_reg(A_PD, d); chk("R6 pending cleared", 32'(d), 0);
      chk("R6 no rearm", 32'(cpu_req), 0);
    end

    // Multi-source patterns retired in ascending order
    for (int k = 0; k < 8; k++) begin
      pat = 16'((k + 1) * 40503);
      irq_in = pat;
      tick();
      irq_in = '0;
      rem = pat;
      while (rem != 0) begin
        e = lowest(rem);
        chk("R5 multi req", 32'(cpu_req), 1);
        chk("R5 multi vec", 32'(cpu_vec), 32'(e));
        ack_once();
        chk("R6 multi drop", 32'(cpu_req), 0);
        rem = rem & ~16'(1 << e);
        tick();
      end
      chk("R6 all retired", 32'(cpu_req), 0);
    end

    // R2 masked sources
    wr_reg(A_EN, 16'hAAAA);
    irq_in = 16'hFFFF; tick(); irq_in = '0; tick();
    rd_reg(A_PD, d); chk("R2 masked pending", 32'(d), 32'hAAAA);
    wr_reg(A_PD, 16'hFFFF);
    rd_reg(A_PD, d); chk("R3 write-one clear", 32'(d), 0);
    wr_reg(A_EN, 16'hFFFF);
    rd_reg(A_PD, d); chk("R2 masked not retained", 32'(d), 0);
    chk("R2 no req", 32'(cpu_req), 0);

    // R1 held input raises one event
    irq_in = 16'h0008; tick();
    chk("R1 edge req", 32'(cpu_req), 1);
    chk("R1 edge vec", 32'(cpu_vec), 3);
    wr_reg(A_PD, 16'h0008);
    tick(); tick();
    rd_reg(A_PD, d); chk("R1 held no re-event", 32'(d), 0);
    chk("R1 held no req", 32'(cpu_req), 0);
    irq_in = '0; tick();

    // R4 master enable
    wr_reg(A_CT, 16'h0000);
    irq_in = 16'h0020; tick(); irq_in = '0; tick(); tick();
    chk("R4 master off no req", 32'(cpu_req), 0);
    rd_reg(A_PD, d); chk("R3 pending with master off", 32'(d), 32'h0020);
    wr_reg(A_CT, 16'h0001);
    chk("R4 master on req", 32'(cpu_req), 1);
    chk("R4 master on vec", 32'(cpu_vec), 5);
    rd_reg(A_CT, d); chk("R4 control read", 32'(d), 1);
    ack_once(); tick();

    // R9 vector register and unmapped address
    irq_in = 16'h0004; tick(); irq_in = '0;
    rd_reg(A_VC, d); chk("R9 vector read", 32'(d), 32'h8002);
    rd_reg(16'h0010, d); chk("R9 unmapped read", 32'(d), 0);
    tick();
    chk("R9 rdata holds", 32'(port_rdata), 0);

    // R8 freeze
    mod_en = 1'b0;
    ack_once();
    chk("R8 ack ignored req", 32'(cpu_req), 1);
    chk("R8 ack ignored vec", 32'(cpu_vec), 2);
    wr_reg(A_EN, 16'h0000);
    irq_in = 16'h0080; tick(); irq_in = '0; tick();
    rd_reg(A_CT, d); chk("R8 read frozen", 32'(d), 0);
    mod_en = 1'b1;
    rd_reg(A_EN, d); chk("R8 write ignored", 32'(d), 32'hFFFF);
    rd_reg(A_PD, d); chk("R8 event ignored", 32'(d), 32'h0004);
    ack_once();
    chk("R6 ack after thaw", 32'(cpu_req), 0);
    tick();
    chk("R6 idle after thaw", 32'(cpu_req), 0);

    // R7 reset after activity
    irq_in = 16'h0200; tick(); irq_in = '0;
    chk("R7 pre-reset req", 32'(cpu_req), 1);
    rst_n = 1'b0; tick(); rst_n = 1'b1; tick();
    chk("R7 req cleared", 32'(cpu_req), 0);
    rd_reg(A_EN, d); chk("R7 enable cleared", 32'(d), 0);
    rd_reg(A_CT, d); chk("R7 control cleared", 32'(d), 0);
    rd_reg(A_PD, d); chk("R7 pending cleared", 32'(d), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule